// File: doc/BRIEF.md
# Receive Overhead Byte Serializer

This block collects the 36 transport overhead bytes of each received frame from a byte stream on the system clock. It then presents them as a serial bit stream on a separate overhead clock. Overhead bytes arrive with a valid flag and move through a 36-entry byte staging register. A strobe that marks the start of the payload area ends the overhead capture for that frame. If a complete set of bytes was seen, that strobe copies the staging register into a holding register and sends a toggle request across to the overhead domain.

The overhead clock runs freely and is unrelated to the system clock. Its serial logic waits for the synchronized request and then reads the holding register in place. It sends one bit per overhead clock cycle in which the shared clock enable is high, so bursts of enable produce bursts of data. The first bit of each frame carries a one-cycle frame marker. When the last bit has been sent, an acknowledge toggle returns to the system side. The holding register stays untouched until that acknowledge arrives. If a new frame finishes capture before the acknowledge returns, the new frame is dropped and a sticky overrun flag is set.

Top module: `ohs_rx_serializer`

## Requirements
- R1: Each system-clock cycle with oh_valid high shifts oh_byte into the staging register. The staging register keeps the most recent 36 bytes in arrival order.
- R2: At spe_start, a transfer happens only if at least 36 valid bytes arrived since the previous spe_start. With fewer bytes, nothing is transferred and no serial frame appears.
- R3: If more than 36 bytes arrived before spe_start, the last 36 of them are the ones sent.
- R4: A frame goes out as 288 bits. Bytes are sent in arrival order, and each byte is sent most significant bit first.
- R5: The serial output moves by exactly one bit on each overhead clock edge that sees ovh_en high while a frame is in progress. It does not move on edges with ovh_en low.
- R6: ser_frame is high for exactly the one enabled overhead cycle that carries the first bit of a frame, and is low at all other times.
- R7: The holding register loaded at spe_start stays unchanged until the overhead side has sent all 288 bits and its acknowledge has been synchronized back.
- R8: An spe_start that ends a full capture while a previous transfer is still outstanding drops the new frame. It also sets overrun, which stays high until reset. The outstanding frame still completes intact.
- R9: Reset clears the outputs: ser_data, ser_frame and overrun are all 0. Each domain has its own synchronous active-low reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for byte capture |
| sys_rst_n | input | 1 | Synchronous active-low reset, system domain |
| oh_byte | input | 8 | Received overhead byte |
| oh_valid | input | 1 | oh_byte holds an overhead byte this cycle |
| spe_start | input | 1 | One-cycle strobe at the start of the payload area |
| overrun | output | 1 | Sticky flag: a full frame was dropped because a transfer was outstanding |
| ovh_clk | input | 1 | Free-running overhead clock |
| ovh_rst_n | input | 1 | Synchronous active-low reset, overhead domain |
| ovh_en | input | 1 | Shared bursty clock enable for the serial output |
| ser_data | output | 1 | Serial overhead data |
| ser_frame | output | 1 | Marks the first bit of a frame |

## Verification
The bench checks that exactly 36 bytes are needed. A 35-byte frame must produce no output, and a 40-byte frame must send its last 36 bytes. A design that miscounts would send a stale or shifted frame. The enable is varied from always-on to very sparse. A serializer that advanced without the enable, or skipped a bit on an enabled cycle, would corrupt the 288-bit comparison or misplace the marker. For the overrun case, a second full frame is pushed in while the first is still being sent. If the holding register were overwritten, or the new frame were queued rather than dropped, the first frame would arrive damaged, an extra frame would appear, or overrun would stay low.

// File: rtl/ohs_pkg.sv
// Shared constants for the receive overhead serializer.
// Assumes one channel of overhead per instance, with byte-wide capture.
package ohs_pkg;
    localparam int OH_BYTES    = 36;
    localparam int OH_BW       = 8;
    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/ohs_sync.sv
// Level synchronizer: carries a single-bit toggle into the clk domain.
// Assumes the input changes no more often than STAGES destination cycles.
module ohs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ohs_capture.sv
// Byte staging on the system clock. Keeps the newest NB bytes in arrival
// order (index 0 oldest) and counts bytes since the last payload strobe.
// Assumes a byte that arrives together with the strobe belongs to the next frame.
module ohs_capture #(
    parameter int NB = 36,
    parameter int BW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BW-1:0]         byte_in,
    input  logic                  valid,
    input  logic                  sop,
    output logic [NB-1:0][BW-1:0] stage,
    output logic                  full
);
    localparam int CW = $clog2(NB + 1);

    logic [CW-1:0] cnt;

    // Shift each valid byte in at the top, oldest byte moves toward index 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
        end else if (valid) begin
            for (int i = 0; i < NB - 1; i++) stage[i] <= stage[i+1];
            stage[NB-1] <= byte_in;
        end
    end

    // Count bytes since the last payload strobe, saturating at NB.
    always_ff @(posedge clk) begin
        if (!rst_n)                            cnt <= '0;
        else if (sop)                          cnt <= valid ? CW'(1) : '0;
        else if (valid && cnt != CW'(NB))      cnt <= cnt + CW'(1);
    end

    assign full = (cnt == CW'(NB));

    // R2
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !sop) |=> full);
    // R2
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sop && !valid) |=> !full);
endmodule

// File: rtl/ohs_launch.sv
// System-side handoff. When the payload strobe ends a full capture, copies
// the staging bytes into a holding register and toggles a request. The
// holding register is frozen until the acknowledge toggle returns.
module ohs_launch #(
    parameter int NB   = 36,
    parameter int BW   = 8,
    parameter int SYNC = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NB-1:0][BW-1:0] stage,
    input  logic                  full,
    input  logic                  sop,
    input  logic                  ack_async,
    output logic [NB-1:0][BW-1:0] hold,
    output logic                  req,
    output logic                  overrun
);
    logic ack_s;
    logic pending;

    ohs_sync #(.STAGES(SYNC)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_async),
        .q     (ack_s)
    );

    assign pending = req ^ ack_s;

    // Launch a transfer, or flag an overrun if one is still outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold    <= '0;
            req     <= 1'b0;
            overrun <= 1'b0;
        end else if (sop && full) begin
            if (!pending) begin
                hold <= stage;
                req  <= ~req;
            end else begin
                overrun <= 1'b1;
            end
        end
    end

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> $stable(hold));
    // R8
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    // R8
    drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sop && full && pending) |=> $stable(req));
endmodule

// File: rtl/ohs_shifter.sv
// Overhead-domain serializer. Detects a new request toggle and reads the
// holding register in place, one bit per enabled cycle, byte 0 first and
// MSB first. Toggles the acknowledge after the final bit.
// Assumes the holding register is static while a request is outstanding.
module ohs_shifter #(
    parameter int NB   = 36,
    parameter int BW   = 8,
    parameter int SYNC = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic [NB-1:0][BW-1:0] hold,
    input  logic                  req_async,
    output logic                  ser_data,
    output logic                  ser_frame,
    output logic                  ack
);
    localparam int BYTE_W = $clog2(NB);
    localparam int BIT_W  = $clog2(BW);

    logic              req_s;
    logic              seen;
    logic              busy;
    logic [BYTE_W-1:0] byte_idx;
    logic [BIT_W-1:0]  bit_idx;
    logic              last_bit;

    ohs_sync #(.STAGES(SYNC)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_async),
        .q     (req_s)
    );

    assign last_bit = (byte_idx == BYTE_W'(NB - 1)) && (bit_idx == BIT_W'(BW - 1));

    // Start on a new request, then emit one bit per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen      <= 1'b0;
            busy      <= 1'b0;
            byte_idx  <= '0;
            bit_idx   <= '0;
            ser_data  <= 1'b0;
            ser_frame <= 1'b0;
            ack       <= 1'b0;
        end else begin
            ser_frame <= 1'b0;
            if (!busy) begin
                ser_data <= 1'b0;
                if (req_s != seen) begin
                    busy     <= 1'b1;
                    seen     <= req_s;
                    byte_idx <= '0;
                    bit_idx  <= '0;
                end
            end else if (en) begin
                ser_data  <= hold[byte_idx][BIT_W'(BW - 1) - bit_idx];
                ser_frame <= (byte_idx == '0) && (bit_idx == '0);
                if (last_bit) begin
                    busy <= 1'b0;
                    ack  <= ~ack;
                end
                if (bit_idx == BIT_W'(BW - 1)) begin
                    bit_idx  <= '0;
                    byte_idx <= byte_idx + BYTE_W'(1);
                end else begin
                    bit_idx  <= bit_idx + BIT_W'(1);
                end
            end
        end
    end

    // R5
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !en) |=> ($stable(byte_idx) && $stable(bit_idx)));
    // R6
    frame_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_frame |-> $past(en));
    // R6
    frame_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_frame |=> !ser_frame);
endmodule

// File: rtl/ohs_rx_serializer.sv
// Top level: receive overhead byte capture on the system clock and serial
// output on the overhead clock, joined by a toggle request/acknowledge.
// Assumes the two clocks are unrelated and each domain has its own reset.
module ohs_rx_serializer
    import ohs_pkg::*;
#(
    parameter int NB   = OH_BYTES,
    parameter int BW   = OH_BW,
    parameter int SYNC = SYNC_STAGES
) (
    input  logic          sys_clk,
    input  logic          sys_rst_n,
    input  logic [BW-1:0] oh_byte,
    input  logic          oh_valid,
    input  logic          spe_start,
    output logic          overrun,
    input  logic          ovh_clk,
    input  logic          ovh_rst_n,
    input  logic          ovh_en,
    output logic          ser_data,
    output logic          ser_frame
);
    logic [NB-1:0][BW-1:0] stage;
    logic [NB-1:0][BW-1:0] hold;
    logic                  full;
    logic                  req;
    logic                  ack;

    ohs_capture #(.NB(NB), .BW(BW)) u_capture (
        .clk     (sys_clk),
        .rst_n   (sys_rst_n),
        .byte_in (oh_byte),
        .valid   (oh_valid),
        .sop     (spe_start),
        .stage   (stage),
        .full    (full)
    );

    ohs_launch #(.NB(NB), .BW(BW), .SYNC(SYNC)) u_launch (
        .clk       (sys_clk),
        .rst_n     (sys_rst_n),
        .stage     (stage),
        .full      (full),
        .sop       (spe_start),
        .ack_async (ack),
        .hold      (hold),
        .req       (req),
        .overrun   (overrun)
    );

    ohs_shifter #(.NB(NB), .BW(BW), .SYNC(SYNC)) u_shifter (
        .clk       (ovh_clk),
        .rst_n     (ovh_rst_n),
        .en        (ovh_en),
        .hold      (hold),
        .req_async (req),
        .ser_data  (ser_data),
        .ser_frame (ser_frame),
        .ack       (ack)
    );
endmodule

// File: tb/ohs_rx_serializer_tb.sv
module ohs_rx_serializer_tb;
    localparam int NB    = 36;
    localparam int BW    = 8;
    localparam int NBITS = NB * BW;

    logic          sys_clk = 1'b0;
    logic          ovh_clk = 1'b0;
    logic          sys_rst_n = 1'b0;
    logic          ovh_rst_n = 1'b0;
    logic [BW-1:0] oh_byte = '0;
    logic          oh_valid = 1'b0;
    logic          spe_start = 1'b0;
    logic          ovh_en = 1'b0;
    logic          overrun;
    logic          ser_data;
    logic          ser_frame;

    int checks = 0;
    int errors = 0;
    int en_pct = 50;
    logic [NBITS-1:0] got_q[$];
    logic             collecting = 1'b0;
    int               nbits = 0;
    logic [NBITS-1:0] acc = '0;

    always #4 sys_clk = ~sys_clk;
    always #7 ovh_clk = ~ovh_clk;

    ohs_rx_serializer u_dut (
        .sys_clk   (sys_clk),
        .sys_rst_n (sys_rst_n),
        .oh_byte   (oh_byte),
        .oh_valid  (oh_valid),
        .spe_start (spe_start),
        .overrun   (overrun),
        .ovh_clk   (ovh_clk),
        .ovh_rst_n (ovh_rst_n),
        .ovh_en    (ovh_en),
        .ser_data  (ser_data),
        .ser_frame (ser_frame)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [NBITS-1:0] act, input logic [NBITS-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Overhead-side monitor: record the bit emitted on the last edge, then pick the next enable.
    always @(negedge ovh_clk) begin
        if (ovh_rst_n && ovh_en) begin
            if (ser_frame) begin
                if (collecting) chk(1'b0, "R6", "marker inside frame", NBITS'(nbits), '0);
                collecting = 1'b1;
                acc = {{(NBITS-1){1'b0}}, ser_data};
                nbits = 1;
            end else if (collecting) begin
                acc = {acc[NBITS-2:0], ser_data};
                nbits++;
            end
            if (collecting && nbits == NBITS) begin
                got_q.push_back(acc);
                collecting = 1'b0;
            end
        end else if (ovh_rst_n && ser_frame) begin
            chk(1'b0, "R6", "marker without enable", 1, 0);
        end
        ovh_en = ovh_rst_n && ($urandom_range(99) < en_pct);
    end

    // Drive n bytes with random gaps, then the payload strobe; return expected bits (R1 R3 R4).
    task automatic send_frame(input int n, output logic [NBITS-1:0] exp);
        logic [BW-1:0] b[64];
        exp = '0;
        for (int i = 0; i < n; i++) begin
            int gap = $urandom_range(2);
            oh_valid = 1'b0;
            repeat (gap) @(negedge sys_clk);
            b[i] = BW'($urandom);
            oh_byte = b[i];
            oh_valid = 1'b1;
            @(negedge sys_clk);
        end
        oh_valid = 1'b0;
        spe_start = 1'b1;
        @(negedge sys_clk);
        spe_start = 1'b0;
        for (int k = (n > NB ? n - NB : 0); k < n; k++) exp = {exp[NBITS-BW-1:0], b[k]};
    endtask

    task automatic wait_frame(input logic [NBITS-1:0] exp, input string req);
        int t = 0;
        while (got_q.size() == 0 && t < 20000) begin
            @(negedge sys_clk);
            t++;
        end
        if (got_q.size() == 0) chk(1'b0, req, "no frame emitted", '0, exp);
        else begin
            logic [NBITS-1:0] g = got_q.pop_front();
            chk(g == exp, req, "frame bits", g, exp);
        end
        repeat (20) @(negedge sys_clk);
    endtask

    task automatic expect_none(input string req);
        repeat (4000) @(negedge sys_clk);
        chk(got_q.size() == 0 && !collecting, req, "unexpected frame", NBITS'(got_q.size()), '0);
        got_q.delete();
    endtask

    task automatic do_reset();
        sys_rst_n = 1'b0;
        ovh_rst_n = 1'b0;
        repeat (6) @(negedge ovh_clk);
        @(negedge sys_clk);
        chk(ser_data == 1'b0 && ser_frame == 1'b0 && overrun == 1'b0, "R9", "reset outputs",
            NBITS'({ser_data, ser_frame, overrun}), '0);
        sys_rst_n = 1'b1;
        ovh_rst_n = 1'b1;
        repeat (4) @(negedge sys_clk);
    endtask

    initial begin
        repeat (190000) @(posedge sys_clk);
        chk(1'b0, "watchdog", "run did not finish", '0, '0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [NBITS-1:0] e;
        logic [NBITS-1:0] ea;
        logic [NBITS-1:0] eb;
        void'($urandom(32'h5eed_0a1c));
        do_reset();

        // R4 R5: continuous enable
        en_pct = 100;
        send_frame(NB, e);
        wait_frame(e, "R4");
        // R5: sparse enable
        en_pct = 12;
        send_frame(NB, e);
        wait_frame(e, "R5");
        // R3: over-long capture keeps the newest 36 bytes
        en_pct = 50;
        send_frame(NB + 4, e);
        wait_frame(e, "R3");
        // R2: short capture produces nothing, next full frame still works
        send_frame(NB - 1, e);
        expect_none("R2");
        send_frame(NB, e);
        wait_frame(e, "R2");

        // R1 R4 R5: constrained random frames
        for (int f = 0; f < 18; f++) begin
            int len = (f % 5 == 3) ? NB - 1 : ((f % 7 == 5) ? NB + 1 : NB);
            en_pct = 20 + $urandom_range(80);
            send_frame(len, e);
            if (len >= NB) wait_frame(e, "R1");
            else           expect_none("R2");
        end
        chk(overrun == 1'b0, "R8", "no overrun in spaced traffic", NBITS'(overrun), '0);

        // R7 R8: second full frame while the first is still shifting
        en_pct = 30;
        send_frame(NB, ea);
        send_frame(NB, eb);
        chk(overrun == 1'b1, "R8", "overrun set", NBITS'(overrun), 1);
        wait_frame(ea, "R7");
        expect_none("R8");
        chk(overrun == 1'b1, "R8", "overrun sticky", NBITS'(overrun), 1);
        chk(eb != ea, "R8", "frames distinct", eb, ea);

        do_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule